// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block sits between a register bus and a serial protocol engine and buffers bytes in both directions. Software writes outgoing bytes into a transmit FIFO that the engine drains over a ready/valid port. The engine fills a receive FIFO over a second ready/valid port, and software reads those bytes back over the bus. Both FIFOs have the same depth, which is a parameter (16 or 32 entries, a power of two).

Each FIFO has a programmable level threshold. The threshold raises a "nearly empty" event on the transmit side and a "nearly full" event on the receive side. Each FIFO can be emptied with a flush bit that clears itself once the flush is done.

All FIFO conditions and four event inputs from the engine are gathered in one 32-bit status word. That word has a mask, a masked view and a write-one-to-clear register. A single interrupt line is the OR of the masked view.

Top module: `fifo_pair_irq`

## Requirements
- R1: Register offsets on `bus_addr`: 0 control, 1 TX data (write), 2 RX data (read), 3 TX threshold, 4 RX threshold, 5 mask, 6 raw status, 7 masked status, 8 clear (write). A read returns its value on `bus_rdata` one cycle after the read is issued. Write-only and unmapped offsets read as 0.
- R2: After reset both FIFOs are empty and both thresholds are 0. The mask reads 0, raw status reads 0x00000033, `irq` is low and `bus_rdata` is 0.
- R3: Bytes written at offset 1 leave on `tx_out_data` in write order. `tx_out_valid` is high while the TX FIFO holds data. Each cycle with `tx_out_ready` high removes one byte.
- R4: A byte on `rx_in_data` is stored when `rx_in_valid` and `rx_in_ready` are both high. A read at offset 2 returns the oldest byte and removes it. A read at offset 2 while the RX FIFO is empty returns 0 and leaves the FIFO as it was.
- R5: Status bit 2 is set while the TX FIFO holds DEPTH bytes. A write at offset 1 while the TX FIFO is full throws the byte away and sets status bit 3. Bit 3 stays set until it is cleared.
- R6: While the RX FIFO holds DEPTH bytes, `rx_in_ready` is low, status bit 6 is set, and any byte offered is dropped.
- R7: A threshold write larger than DEPTH/2-1 stores DEPTH/2-1 (7 when DEPTH is 16). A smaller value is stored as written. Both thresholds read back as stored.
- R8: Status bit 0 is set when the TX FIFO is empty and bit 4 when the RX FIFO is empty. Bit 1 is set while the TX count is at or below the TX threshold. Bit 5 is set while the RX count is at or above the RX threshold.
- R9: Writing control bit 7 flushes the TX FIFO and writing control bit 8 flushes the RX FIFO. A control read issued in the next cycle shows the written bit as 1. Later reads show 0, and the flushed FIFO is then empty. While a flush is pending, `tx_out_valid` (TX flush) or `rx_in_ready` (RX flush) is held low.
- R10: A high level on `evt_in[0]`, `evt_in[1]`, `evt_in[2]` or `evt_in[3]` sets status bit 19, 24, 25 or 28 respectively. The bit stays set until it is cleared.
- R11: Only the bits of 0x131F007F in the mask are writable. Masked status equals raw status AND mask. `irq` is high exactly when masked status is nonzero.
- R12: Writing 1s at offset 8 clears the matching latched bits (3, 19, 24, 25, 28). The clear-all value is 0x131F007F. Level bits (0, 1, 2, 4, 5, 6) keep following the FIFO state and are not affected by a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_out_valid | output | 1 | TX byte available to engine |
| tx_out_data | output | 8 | Oldest TX byte |
| tx_out_ready | input | 1 | Engine takes the TX byte |
| rx_in_valid | input | 1 | Engine offers an RX byte |
| rx_in_data | input | 8 | Offered RX byte |
| rx_in_ready | output | 1 | RX FIFO can accept a byte |
| evt_in | input | 4 | Engine event pulses |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
The assertions take for granted a single-master bus with at most one access per cycle, and engine event inputs that are clean synchronous levels sampled at the clock edge. They also rely on a depth that is a power of two, so the pointer wrap is natural. The stimulus drives every input half a cycle away from the sampling edge and issues one bus access or one engine handshake at a time. The random mix of FIFO writes, drains, reads, events, mask writes and clears is therefore always a legal sequence. The bench model then predicts the whole status word after every step.

// File: rtl/fp_pkg.sv
package fp_pkg;
    localparam logic [3:0] ADR_CTRL   = 4'd0;
    localparam logic [3:0] ADR_TXDATA = 4'd1;
    localparam logic [3:0] ADR_RXDATA = 4'd2;
    localparam logic [3:0] ADR_TXTHR  = 4'd3;
    localparam logic [3:0] ADR_RXTHR  = 4'd4;
    localparam logic [3:0] ADR_MASK   = 4'd5;
    localparam logic [3:0] ADR_RAW    = 4'd6;
    localparam logic [3:0] ADR_MSKD   = 4'd7;
    localparam logic [3:0] ADR_CLEAR  = 4'd8;

    localparam int CTL_FLUSH_TX = 7;
    localparam int CTL_FLUSH_RX = 8;

    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_LOW   = 1;
    localparam int ST_TX_FULL  = 2;
    localparam int ST_TX_OVR   = 3;
    localparam int ST_RX_EMPTY = 4;
    localparam int ST_RX_HIGH  = 5;
    localparam int ST_RX_FULL  = 6;
    localparam int ST_EVT0     = 19;
    localparam int ST_EVT1     = 24;
    localparam int ST_EVT2     = 25;
    localparam int ST_EVT3     = 28;

    localparam logic [31:0] ALL_EVENTS   = 32'h131F_007F;
    localparam logic [31:0] STICKY_BITS  = 32'h1308_0008;
    localparam logic [31:0] LEVEL_BITS   = 32'h0000_0077;
endpackage

// File: rtl/fp_byte_fifo.sv
module fp_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [7:0]                   push_data,
    input  logic                         pop,
    output logic [7:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [7:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (st_q.cnt != CW'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wptr = st_q.wptr + PW'(1);
            if (do_pop)  st_d.rptr = st_q.rptr + PW'(1);
            unique case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wptr] <= push_data;
    end

    assign head  = mem[st_q.rptr];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/fp_event_regs.sv
module fp_event_regs
    import fp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] level_in,
    input  logic [31:0] set_in,
    input  logic [31:0] clr_in,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    output logic [31:0] raw,
    output logic [31:0] masked,
    output logic [31:0] mask,
    output logic        irq
);
    typedef struct packed {
        logic [31:0] sticky;
        logic [31:0] mask;
    } ev_st_t;

    ev_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sticky = ((st_q.sticky & ~clr_in) | set_in) & STICKY_BITS;
        if (mask_we) st_d.mask = mask_wdata & ALL_EVENTS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw    = (level_in & LEVEL_BITS) | st_q.sticky;
    assign mask   = st_q.mask;
    assign masked = raw & st_q.mask;
    assign irq    = |masked;
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
    import fp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_out_valid,
    output logic [7:0]  tx_out_data,
    input  logic        tx_out_ready,
    input  logic        rx_in_valid,
    input  logic [7:0]  rx_in_data,
    output logic        rx_in_ready,
    input  logic [3:0]  evt_in,
    output logic        irq
);
    localparam int CW      = $clog2(DEPTH + 1);
    localparam int THR_MAX = DEPTH / 2 - 1;
    localparam int THR_W   = $clog2(DEPTH / 2);

    typedef struct packed {
        logic             flush_tx;
        logic             flush_rx;
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic [31:0]      rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]    rx_head;
    logic          wr_en, rd_en, tx_push, rx_pop;
    logic [31:0]   level_vec, set_vec, clr_vec;
    logic [31:0]   raw_stat, masked_stat, mask_reg;
    logic          mask_we;
    logic          tx_flush_pend, rx_flush_pend;

    function automatic logic [THR_W-1:0] clamp_thr(input logic [31:0] v);
        if (v > 32'(THR_MAX)) return THR_W'(THR_MAX);
        return v[THR_W-1:0];
    endfunction

    assign tx_flush_pend = st_q.flush_tx;
    assign rx_flush_pend = st_q.flush_rx;

    fp_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(st_q.flush_tx),
        .push(tx_push), .push_data(bus_wdata[7:0]),
        .pop(tx_out_ready), .head(tx_out_data),
        .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    fp_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .flush(st_q.flush_rx),
        .push(rx_in_valid), .push_data(rx_in_data),
        .pop(rx_pop), .head(rx_head),
        .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    fp_event_regs u_events (
        .clk(clk), .rst_n(rst_n),
        .level_in(level_vec), .set_in(set_vec), .clr_in(clr_vec),
        .mask_we(mask_we), .mask_wdata(bus_wdata),
        .raw(raw_stat), .masked(masked_stat), .mask(mask_reg), .irq(irq)
    );

    always_comb begin
        wr_en   = bus_valid && bus_write;
        rd_en   = bus_valid && !bus_write;
        tx_push = wr_en && (bus_addr == ADR_TXDATA);
        rx_pop  = rd_en && (bus_addr == ADR_RXDATA);
        mask_we = wr_en && (bus_addr == ADR_MASK);
        clr_vec = (wr_en && (bus_addr == ADR_CLEAR)) ? bus_wdata : '0;

        level_vec              = '0;
        level_vec[ST_TX_EMPTY] = tx_empty;
        level_vec[ST_TX_LOW]   = (tx_count <= CW'(st_q.tx_thr));
        level_vec[ST_TX_FULL]  = tx_full;
        level_vec[ST_RX_EMPTY] = rx_empty;
        level_vec[ST_RX_HIGH]  = (rx_count >= CW'(st_q.rx_thr));
        level_vec[ST_RX_FULL]  = rx_full;

        set_vec            = '0;
        set_vec[ST_TX_OVR] = tx_push && tx_full;
        set_vec[ST_EVT0]   = evt_in[0];
        set_vec[ST_EVT1]   = evt_in[1];
        set_vec[ST_EVT2]   = evt_in[2];
        set_vec[ST_EVT3]   = evt_in[3];

        st_d          = st_q;
        st_d.flush_tx = wr_en && (bus_addr == ADR_CTRL) && bus_wdata[CTL_FLUSH_TX];
        st_d.flush_rx = wr_en && (bus_addr == ADR_CTRL) && bus_wdata[CTL_FLUSH_RX];
        if (wr_en && bus_addr == ADR_TXTHR) st_d.tx_thr = clamp_thr(bus_wdata);
        if (wr_en && bus_addr == ADR_RXTHR) st_d.rx_thr = clamp_thr(bus_wdata);

        if (rd_en) begin
            st_d.rdata = '0;
            unique case (bus_addr)
                ADR_CTRL: begin
                    st_d.rdata[CTL_FLUSH_TX] = st_q.flush_tx;
                    st_d.rdata[CTL_FLUSH_RX] = st_q.flush_rx;
                end
                ADR_RXDATA: st_d.rdata = rx_empty ? '0 : {24'd0, rx_head};
                ADR_TXTHR:  st_d.rdata = 32'(st_q.tx_thr);
                ADR_RXTHR:  st_d.rdata = 32'(st_q.rx_thr);
                ADR_MASK:   st_d.rdata = mask_reg;
                ADR_RAW:    st_d.rdata = raw_stat;
                ADR_MSKD:   st_d.rdata = masked_stat;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign tx_out_valid = !tx_empty && !st_q.flush_tx;
    assign rx_in_ready  = !rx_full && !st_q.flush_rx;
endmodule

// File: rtl/fifo_pair_irq_chk.sv
module fifo_pair_irq_chk
    import fp_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_valid,
    input logic                       bus_write,
    input logic [3:0]                 bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [3:0]                 evt_in,
    input logic                       rx_in_ready,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] tx_count,
    input logic [$clog2(DEPTH+1)-1:0] rx_count,
    input logic                       tx_full,
    input logic                       tx_flush_pend,
    input logic                       rx_flush_pend,
    input logic [31:0]                raw_stat,
    input logic [31:0]                mask_reg
);
    logic wr_ctrl, wr_tx, wr_clr;
    assign wr_ctrl = bus_valid && bus_write && (bus_addr == ADR_CTRL);
    assign wr_tx   = bus_valid && bus_write && (bus_addr == ADR_TXDATA);
    assign wr_clr  = bus_valid && bus_write && (bus_addr == ADR_CLEAR);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_count) <= DEPTH) && (32'(rx_count) <= DEPTH));

    assert_overrun_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> raw_stat[ST_TX_OVR]);

    assert_rx_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_count) == DEPTH) |-> !rx_in_ready);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush_pend |=> (tx_count == '0));

    assert_flush_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush_pend && !(wr_ctrl && bus_wdata[CTL_FLUSH_RX])) |=> !rx_flush_pend);

    assert_event_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_in[2] |=> raw_stat[ST_EVT2]);

    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_reg != '0));

    assert_clear_overrun_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && bus_wdata[ST_TX_OVR] && !(wr_tx && tx_full)) |=> !raw_stat[ST_TX_OVR]);
endmodule

bind fifo_pair_irq fifo_pair_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_in(evt_in),
    .rx_in_ready(rx_in_ready), .irq(irq), .tx_count(tx_count),
    .rx_count(rx_count), .tx_full(tx_full), .tx_flush_pend(tx_flush_pend),
    .rx_flush_pend(rx_flush_pend), .raw_stat(raw_stat), .mask_reg(mask_reg)
);

// File: tb/fifo_pair_irq_tb.sv
module fifo_pair_irq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam logic [31:0] CLR_ALL = 32'h131F_007F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_out_valid, tx_out_ready = 1'b0;
    logic [7:0]  tx_out_data;
    logic        rx_in_valid = 1'b0, rx_in_ready;
    logic [7:0]  rx_in_data = '0;
    logic [3:0]  evt_in = '0;
    logic        irq;

    int total = 0;
    int bad = 0;

    int tx_m[$];
    int rx_m[$];
    bit ovr_m;
    bit [3:0] ev_m;
    int txthr_m, rxthr_m;
    logic [31:0] mask_m;

    fifo_pair_irq #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
        .evt_in(evt_in), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_raw();
        logic [31:0] r = '0;
        r[0]  = (tx_m.size() == 0);
        r[1]  = (tx_m.size() <= txthr_m);
        r[2]  = (tx_m.size() == DEPTH);
        r[3]  = ovr_m;
        r[4]  = (rx_m.size() == 0);
        r[5]  = (rx_m.size() >= rxthr_m);
        r[6]  = (rx_m.size() == DEPTH);
        r[19] = ev_m[0];
        r[24] = ev_m[1];
        r[25] = ev_m[2];
        r[28] = ev_m[3];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tx_write(input logic [7:0] b);
        bus_wr(4'd1, {24'd0, b});
        if (tx_m.size() == DEPTH) ovr_m = 1'b1;
        else tx_m.push_back(int'(b));
    endtask

    task automatic tx_drain_one(input string req);
        if (tx_m.size() == 0) begin
            chk(req, {31'd0, tx_out_valid}, 32'd0);
        end else begin
            chk(req, {31'd0, tx_out_valid}, 32'd1);
            chk(req, {24'd0, tx_out_data}, 32'(tx_m.pop_front()));
            tx_out_ready = 1'b1;
            @(negedge clk);
            tx_out_ready = 1'b0;
        end
    endtask

    task automatic rx_offer(input logic [7:0] b, input string req);
        chk(req, {31'd0, rx_in_ready}, {31'd0, (rx_m.size() < DEPTH)});
        rx_in_valid = 1'b1; rx_in_data = b;
        @(negedge clk);
        rx_in_valid = 1'b0;
        if (rx_m.size() < DEPTH) rx_m.push_back(int'(b));
    endtask

    task automatic rx_read(input string req);
        logic [31:0] d;
        bus_rd(4'd2, d);
        if (rx_m.size() == 0) chk(req, d, 32'd0);
        else chk(req, d, 32'(rx_m.pop_front()));
    endtask

    task automatic do_clear(input logic [31:0] v);
        bus_wr(4'd8, v);
        if (v[3]) ovr_m = 1'b0;
        if (v[19]) ev_m[0] = 1'b0;
        if (v[24]) ev_m[1] = 1'b0;
        if (v[25]) ev_m[2] = 1'b0;
        if (v[28]) ev_m[3] = 1'b0;
    endtask

    task automatic pulse_evt(input logic [3:0] v);
        evt_in = v;
        @(negedge clk);
        evt_in = '0;
        ev_m = ev_m | v;
    endtask

    task automatic check_raw(input string req);
        logic [31:0] d;
        bus_rd(4'd6, d);
        chk(req, d, exp_raw());
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |(exp_raw() & mask_m)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED));
        ovr_m = 0; ev_m = '0; txthr_m = 0; rxthr_m = 0; mask_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        chk("R2 rdata", bus_rdata, 32'd0);
        chk("R2 irq", {31'd0, irq}, 32'd0);
        chk("R2 tx_out_valid", {31'd0, tx_out_valid}, 32'd0);
        chk("R2 rx_in_ready", {31'd0, rx_in_ready}, 32'd1);
        bus_rd(4'd6, d); chk("R2 raw", d, 32'h0000_0033);
        bus_rd(4'd5, d); chk("R2 mask", d, 32'd0);
        bus_rd(4'd3, d); chk("R2 txthr", d, 32'd0);
        bus_rd(4'd9, d); chk("R1 unmapped", d, 32'd0);
        bus_rd(4'd1, d); chk("R1 write-only", d, 32'd0);

        // R7 threshold clamp
        bus_wr(4'd3, 32'd100); bus_rd(4'd3, d); chk("R7 tx clamp", d, 32'd7);
        bus_wr(4'd4, 32'd9);   bus_rd(4'd4, d); chk("R7 rx clamp", d, 32'd7);
        bus_wr(4'd4, 32'd5);   bus_rd(4'd4, d); chk("R7 rx keep", d, 32'd5);
        bus_wr(4'd3, 32'd3);   bus_rd(4'd3, d); chk("R7 tx keep", d, 32'd3);
        txthr_m = 3; rxthr_m = 5;

        // R3 R5 R8 fill TX to full, then overrun
        for (int i = 0; i < DEPTH; i++) begin
            tx_write(8'(i * 7 + 1));
            check_raw("R8 tx fill");
        end
        check_raw("R5 full");
        tx_write(8'hEE);
        check_raw("R5 overrun");
        for (int i = 0; i < DEPTH; i++) tx_drain_one("R3 order");
        chk("R5 discarded", {31'd0, tx_out_valid}, 32'd0);
        check_raw("R5 sticky");
        do_clear(32'h0000_0008);
        check_raw("R12 clear overrun");

        // R4 R6 RX path
        rx_read("R4 empty read");
        check_raw("R4 empty unchanged");
        for (int i = 0; i < DEPTH; i++) begin
            rx_offer(8'(8'hA0 + i), "R6 ready");
            check_raw("R8 rx fill");
        end
        rx_offer(8'h55, "R6 full ready");
        check_raw("R6 full");
        for (int i = 0; i < DEPTH; i++) rx_read("R4 order");
        rx_read("R4 empty after");

        // R9 flush
        for (int i = 0; i < 5; i++) tx_write(8'(i + 16));
        for (int i = 0; i < 3; i++) rx_offer(8'(i + 32), "R9 setup");
        bus_wr(4'd0, 32'h0000_0180);
        chk("R9 tx valid held", {31'd0, tx_out_valid}, 32'd0);
        chk("R9 rx ready held", {31'd0, rx_in_ready}, 32'd0);
        bus_rd(4'd0, d); chk("R9 pending", d, 32'h0000_0180);
        bus_rd(4'd0, d); chk("R9 selfclear", d, 32'd0);
        tx_m.delete(); rx_m.delete();
        check_raw("R9 emptied");

        // R10 R11 R12 events, mask, clear
        pulse_evt(4'b1111);
        check_raw("R10 events");
        bus_wr(4'd5, 32'hFFFF_FFFF); mask_m = CLR_ALL;
        bus_rd(4'd5, d); chk("R11 mask bits", d, CLR_ALL);
        bus_rd(4'd7, d); chk("R11 masked", d, exp_raw() & mask_m);
        bus_wr(4'd5, 32'h1000_0000); mask_m = 32'h1000_0000;
        chk("R11 irq on", {31'd0, irq}, 32'd1);
        do_clear(CLR_ALL);
        check_raw("R12 clear all keeps levels");
        chk("R11 irq off", {31'd0, irq}, 32'd0);
        bus_wr(4'd5, 32'h0000_0001); mask_m = 32'h1;
        chk("R11 level irq", {31'd0, irq}, 32'd1);

        // random mix
        for (int i = 0; i < 700; i++) begin
            int op = $urandom_range(0, 11);
            case (op)
                0, 1, 2: tx_write(8'($urandom));
                3, 4:    tx_drain_one("R3 random");
                5, 6:    rx_offer(8'($urandom), "R6 random");
                7, 8:    rx_read("R4 random");
                9:       do_clear($urandom & CLR_ALL);
                10:      pulse_evt(4'($urandom));
                default: begin
                    logic [31:0] m = $urandom;
                    bus_wr(4'd5, m);
                    mask_m = m & CLR_ALL;
                end
            endcase
            check_raw("R8 random");
        end
        bus_rd(4'd7, d); chk("R11 masked final", d, exp_raw() & mask_m);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule